// File: doc/BRIEF.md
# Adaptive Context Model Store with Same-Index Forwarding

This block keeps the adaptive probability models used by a binary arithmetic coder that takes one regular bin per clock. Each model is seven bits wide: a 6-bit probability state and the value of the more probable symbol (MPS). A serializer presents at most one bin per cycle, with its context index, its value, and a flag that marks it as bypass. For a regular bin the block reads the model from a synchronous RAM. It hands that model, with the bin value, to the coder stage one clock later. It also computes the adapted model through a 128-entry transition table and writes the result back.

A RAM read issued while an update to the same entry is still being written would return an out-of-date model. The block prevents this by keeping the indices and results of the last two regular updates and comparing the bin's index against them. On a match it uses the kept result in place of the RAM output, so bins that reuse one context, back to back or one apart, never stall. Before coding starts, a load port fills the RAM with initial models. The write path can have one or two cycles of write-to-read latency, selected by a parameter.

Top module: `ctx_model_store`

## Requirements
- R1: After reset, `out_vld` is low until a regular bin has been accepted.
- R2: A load writes `ld_model` into entry `ld_idx`. A regular bin on that index presented at least three cycles after the load sees exactly the loaded model. Model encoding: bit 6 = MPS value, bits 5:0 = probability state.
- R3: A regular bin (`bin_vld`=1, `bin_byp`=0) is accepted in the cycle it is presented. Its model appears on `out_model` with `out_vld`=1 after the next rising edge.
- R4: When the bin value equals the model's MPS, the next model keeps the MPS and the state rises by one. States 62 and 63 stay unchanged.
- R5: When the bin value differs from the MPS, the next state follows the standard LPS transition table, and the MPS inverts only if the state was 0.
- R6: Consecutive regular bins with the same context index are each accepted in their own cycle, and each sees the model produced by the one before it.
- R7: A regular bin whose index matches the regular bin two before it, with a different index between them, sees the model that earlier bin produced.
- R8: A bypass bin or an idle cycle produces no output and updates no model.
- R9: `out_bin` carries the value of the bin whose model is on `out_model`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write an initial model into the RAM |
| ld_idx | input | IDX_W | Entry written by the load |
| ld_model | input | 7 | Initial model {MPS, state} |
| bin_vld | input | 1 | A bin is presented this cycle |
| bin_byp | input | 1 | The presented bin is bypass coded |
| bin_idx | input | IDX_W | Context index of the bin |
| bin_val | input | 1 | Bin value |
| out_vld | output | 1 | Model output is valid |
| out_model | output | 7 | Model used by the bin, before adaptation |
| out_bin | output | 1 | Value of that bin |

## Verification
The assertions rely on loads never coinciding with a regular bin at the input or in the first pipeline stage. They also rely on the reset being released with the bin inputs idle. The bench keeps loading and coding in separate phases with idle cycles between them. Its random phases draw indices first from a four-entry window, which forces frequent repeats one and two apart, and then from the full range. Bypass and idle cycles are mixed in, so held forwarding entries are exercised across gaps.

// File: rtl/cms_pkg.sv
package cms_pkg;

   localparam int unsigned CMS_STATE_W = 6;
   localparam int unsigned CMS_MODEL_W = CMS_STATE_W + 1;
   localparam int unsigned CMS_LUT_DEPTH = 2 ** (CMS_STATE_W + 1);
   localparam logic [CMS_STATE_W-1:0] CMS_SAT_STATE = 6'd62;

   typedef struct packed {
      logic                   mps;
      logic [CMS_STATE_W-1:0] state;
   } cms_model_t;

   // Next state after a less probable symbol.
   function automatic logic [CMS_STATE_W-1:0] cms_lps_next(input logic [CMS_STATE_W-1:0] s);
      logic [CMS_STATE_W-1:0] r;
      case (s)
         6'd0, 6'd1:                  r = 6'd0;
         6'd2:                        r = 6'd1;
         6'd3, 6'd4:                  r = 6'd2;
         6'd5, 6'd6:                  r = 6'd4;
         6'd7:                        r = 6'd5;
         6'd8:                        r = 6'd6;
         6'd9:                        r = 6'd7;
         6'd10:                       r = 6'd8;
         6'd11, 6'd12:                r = 6'd9;
         6'd13, 6'd14:                r = 6'd11;
         6'd15:                       r = 6'd12;
         6'd16, 6'd17:                r = 6'd13;
         6'd18, 6'd19:                r = 6'd15;
         6'd20, 6'd21:                r = 6'd16;
         6'd22, 6'd23:                r = 6'd18;
         6'd24, 6'd25:                r = 6'd19;
         6'd26, 6'd27:                r = 6'd21;
         6'd28, 6'd29:                r = 6'd22;
         6'd30:                       r = 6'd23;
         6'd31, 6'd32:                r = 6'd24;
         6'd33:                       r = 6'd25;
         6'd34, 6'd35:                r = 6'd26;
         6'd36, 6'd37:                r = 6'd27;
         6'd38:                       r = 6'd28;
         6'd39, 6'd40:                r = 6'd29;
         6'd41, 6'd42, 6'd43:         r = 6'd30;
         6'd44:                       r = 6'd31;
         6'd45, 6'd46:                r = 6'd32;
         6'd47, 6'd48, 6'd49:         r = 6'd33;
         6'd50, 6'd51:                r = 6'd34;
         6'd52, 6'd53, 6'd54:         r = 6'd35;
         6'd55, 6'd56, 6'd57:         r = 6'd36;
         6'd58, 6'd59, 6'd60:         r = 6'd37;
         6'd61, 6'd62:                r = 6'd38;
         default:                     r = 6'd63;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cms_trans_lut.sv
module cms_trans_lut
   import cms_pkg::*;
(
   input  cms_model_t cur,
   input  logic       bin,
   output cms_model_t nxt
);

   // Entry layout: bit 6 = MPS invert flag, bits 5:0 = next state.
   // Table index: {state, bin equals MPS}.
   logic [CMS_MODEL_W-1:0] tab [CMS_LUT_DEPTH];

   for (genvar gi = 0; gi < CMS_LUT_DEPTH; gi++) begin : g_tab
      localparam logic [CMS_STATE_W-1:0] ST = CMS_STATE_W'(gi / 2);
      localparam bit HIT = (gi % 2) == 1;
      if (HIT) begin : g_mps
         assign tab[gi] = {1'b0, (ST < CMS_SAT_STATE) ? ST + 6'd1 : ST};
      end else begin : g_lps
         assign tab[gi] = {(ST == 6'd0), cms_lps_next(ST)};
      end
   end

   logic [CMS_STATE_W:0] lut_idx;
   logic [CMS_MODEL_W-1:0] ent;

   always_comb begin
      lut_idx   = {cur.state, (bin == cur.mps)};
      ent       = tab[lut_idx];
      nxt.mps   = cur.mps ^ ent[CMS_MODEL_W-1];
      nxt.state = ent[CMS_STATE_W-1:0];
   end

endmodule

// File: rtl/cms_model_ram.sv
module cms_model_ram
   import cms_pkg::*;
#(
   parameter int unsigned DEPTH   = 32,
   parameter int unsigned WR_PIPE = 1,
   localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output cms_model_t    rd_data,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  cms_model_t    wd
);

   cms_model_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_addr];
   end

   if (WR_PIPE == 0) begin : g_wr_direct
      always_ff @(posedge clk) begin
         if (we) mem[wa] <= wd;
      end
   end else begin : g_wr_reg
      logic          we_q;
      logic [AW-1:0] wa_q;
      cms_model_t    wd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            we_q <= 1'b0;
            wa_q <= '0;
            wd_q <= '0;
         end else begin
            we_q <= we;
            wa_q <= wa;
            wd_q <= wd;
         end
      end
      always_ff @(posedge clk) begin
         if (we_q) mem[wa_q] <= wd_q;
      end
   end

endmodule

// File: rtl/cms_fwd_sel.sv
module cms_fwd_sel
   import cms_pkg::*;
#(
   parameter int unsigned IDX_W = 5
)(
   input  logic [IDX_W-1:0] s1_idx,
   input  cms_model_t       ram_q,
   input  logic             f1_vld,
   input  logic [IDX_W-1:0] f1_idx,
   input  cms_model_t       f1_model,
   input  logic             f2_vld,
   input  logic [IDX_W-1:0] f2_idx,
   input  cms_model_t       f2_model,
   output cms_model_t       cur
);

   logic hit1, hit2;

   // The newest update wins; the older one only covers a write still in flight.
   always_comb begin
      hit1 = f1_vld && (f1_idx == s1_idx);
      hit2 = f2_vld && (f2_idx == s1_idx);
      if (hit1)      cur = f1_model;
      else if (hit2) cur = f2_model;
      else           cur = ram_q;
   end

endmodule

// File: rtl/ctx_model_store.sv
module ctx_model_store
   import cms_pkg::*;
#(
   parameter int unsigned NUM_CTX = 32,
   parameter int unsigned WR_PIPE = 1,
   localparam int unsigned IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic [6:0]       ld_model,
   input  logic             bin_vld,
   input  logic             bin_byp,
   input  logic [IDX_W-1:0] bin_idx,
   input  logic             bin_val,
   output logic             out_vld,
   output logic [6:0]       out_model,
   output logic             out_bin
);

   if (NUM_CTX < 2) begin : g_chk_depth
      $error("NUM_CTX must be at least 2");
   end
   if (WR_PIPE > 1) begin : g_chk_pipe
      $error("WR_PIPE must be 0 or 1");
   end

   logic acc;
   assign acc = bin_vld && !bin_byp;

   // Stage 1: bin accepted, model arrives from RAM.
   logic             s1_vld;
   logic [IDX_W-1:0] s1_idx;
   logic             s1_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_idx <= '0;
         s1_val <= 1'b0;
      end else begin
         s1_vld <= acc;
         if (acc) begin
            s1_idx <= bin_idx;
            s1_val <= bin_val;
         end
      end
   end

   cms_model_t ram_q, cur, upd, wr_data;
   logic             wr_en;
   logic [IDX_W-1:0] wr_addr;

   assign wr_en   = ld_en || s1_vld;
   assign wr_addr = ld_en ? ld_idx : s1_idx;
   assign wr_data = ld_en ? cms_model_t'(ld_model) : upd;

   cms_model_ram #(.DEPTH(NUM_CTX), .WR_PIPE(WR_PIPE)) ram_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (acc),
      .rd_addr (bin_idx),
      .rd_data (ram_q),
      .we      (wr_en),
      .wa      (wr_addr),
      .wd      (wr_data)
   );

   // Last two regular updates, held across bypass and idle cycles.
   logic             f1_vld, f2_vld;
   logic [IDX_W-1:0] f1_idx, f2_idx;
   cms_model_t       f1_model, f2_model;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f1_vld   <= 1'b0;
         f2_vld   <= 1'b0;
         f1_idx   <= '0;
         f2_idx   <= '0;
         f1_model <= '0;
         f2_model <= '0;
      end else if (ld_en) begin
         f1_vld <= 1'b0;
         f2_vld <= 1'b0;
      end else if (s1_vld) begin
         f1_vld   <= 1'b1;
         f1_idx   <= s1_idx;
         f1_model <= upd;
         f2_vld   <= f1_vld;
         f2_idx   <= f1_idx;
         f2_model <= f1_model;
      end
   end

   cms_fwd_sel #(.IDX_W(IDX_W)) fwd_i (
      .s1_idx   (s1_idx),
      .ram_q    (ram_q),
      .f1_vld   (f1_vld),
      .f1_idx   (f1_idx),
      .f1_model (f1_model),
      .f2_vld   (f2_vld),
      .f2_idx   (f2_idx),
      .f2_model (f2_model),
      .cur      (cur)
   );

   cms_trans_lut lut_i (
      .cur (cur),
      .bin (s1_val),
      .nxt (upd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         out_model <= '0;
         out_bin   <= 1'b0;
      end else begin
         out_vld   <= s1_vld;
         out_model <= cur;
         out_bin   <= s1_val;
      end
   end

   a_r2_load_apart: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |-> (!acc && !s1_vld));

   a_r6_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> ##2 out_vld);

   a_r8_bypass_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |-> ##2 !out_vld);

   a_r9_bin_echo: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> ##2 (out_bin == $past(bin_val, 2)));

   a_r4_match_keeps_mps: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && (cur.mps == s1_val)) |-> (upd.mps == cur.mps && upd.state >= cur.state));

   a_r5_flip_rule: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && (upd.mps != cur.mps)) |-> (cur.state == 6'd0 && cur.mps != s1_val));

endmodule

// File: tb/ctx_model_store_tb.sv
module ctx_model_store_tb_top;

   localparam int unsigned NCTX = 32;
   localparam int unsigned IW   = $clog2(NCTX);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_en = 1'b0;
   logic [IW-1:0] ld_idx = '0;
   logic [6:0]    ld_model = '0;
   logic          bin_vld = 1'b0;
   logic          bin_byp = 1'b0;
   logic [IW-1:0] bin_idx = '0;
   logic          bin_val = 1'b0;
   logic          out_vld;
   logic [6:0]    out_model;
   logic          out_bin;

   always #2.5 clk = ~clk;

   ctx_model_store #(.NUM_CTX(NCTX), .WR_PIPE(1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_model(ld_model),
      .bin_vld(bin_vld), .bin_byp(bin_byp), .bin_idx(bin_idx), .bin_val(bin_val),
      .out_vld(out_vld), .out_model(out_model), .out_bin(out_bin)
   );

   int checks = 0;
   int errors = 0;

   logic [5:0] lps_ref [64] = '{
      0, 0, 1, 2, 2, 4, 4, 5, 6, 7, 8, 9, 9,11,11,12,
     13,13,15,15,16,16,18,18,19,19,21,21,22,22,23,24,
     24,25,26,26,27,27,28,29,29,30,30,30,31,32,32,33,
     33,33,34,34,35,35,35,36,36,36,37,37,37,38,38,63};

   logic [6:0] ref_mem [NCTX];

   // Pending expectations: slot 1 = driven last negedge, slot 2 = two ago.
   logic       p1_v = 0, p2_v = 0;
   logic [6:0] p1_m, p2_m;
   logic       p1_b, p2_b;
   string      p1_t = "", p2_t = "";

   function automatic logic [6:0] ref_next(input logic [6:0] m, input logic b);
      logic       mps;
      logic [5:0] st;
      mps = m[6];
      st  = m[5:0];
      if (b == mps) begin
         if (st < 6'd62) st = st + 6'd1;
      end else begin
         if (st == 6'd0) mps = ~mps;
         st = lps_ref[st];
      end
      return {mps, st};
   endfunction

   task automatic check_out();
      checks++;
      if (p2_v) begin
         if (!(out_vld === 1'b1 && out_model === p2_m && out_bin === p2_b)) begin
            errors++;
            $display("FAIL %s: got vld=%b model=%h bin=%b, expected vld=1 model=%h bin=%b",
                     p2_t, out_vld, out_model, out_bin, p2_m, p2_b);
         end
      end else if (out_vld !== 1'b0) begin
         errors++;
         $display("FAIL R8: got vld=%b, expected vld=0", out_vld);
      end
   endtask

   task automatic step(input logic ld, input logic [IW-1:0] li, input logic [6:0] lm,
                       input logic v, input logic byp, input logic [IW-1:0] idx,
                       input logic val, input string tag);
      @(negedge clk);
      check_out();
      p2_v = p1_v; p2_m = p1_m; p2_b = p1_b; p2_t = p1_t;
      ld_en = ld; ld_idx = li; ld_model = lm;
      bin_vld = v; bin_byp = byp; bin_idx = idx; bin_val = val;
      if (ld) ref_mem[li] = lm;
      p1_v = v && !byp;
      if (p1_v) begin
         p1_m = ref_mem[idx];
         p1_b = val;
         p1_t = tag;
         ref_mem[idx] = ref_next(ref_mem[idx], val);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0, '0, 0, "R8");
   endtask

   task automatic reg_bin(input logic [IW-1:0] idx, input logic val, input string tag);
      step(0, '0, '0, 1, 0, idx, val, tag);
   endtask

   task automatic load(input logic [IW-1:0] idx, input logic [6:0] m);
      step(1, idx, m, 0, 0, '0, 0, "R2");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: idle output after reset
      @(negedge clk);
      checks++;
      if (out_vld !== 1'b0) begin
         errors++;
         $display("FAIL R1: got vld=%b, expected vld=0", out_vld);
      end

      // R2: initial loading of every entry
      for (int i = 0; i < NCTX; i++)
         load(IW'(i), {1'($urandom), 6'($urandom % 63)});
      load(1, {1'b1, 6'd60});
      load(2, {1'b0, 6'd0});
      load(4, {1'b0, 6'd10});
      idle(3);

      reg_bin(0, 0, "R2");
      reg_bin(3, 1, "R3");
      // R4 and R6: run of MPS bins on one index up to saturation
      for (int i = 0; i < 5; i++) reg_bin(1, 1, "R4");
      // R5: LPS at state 0 flips MPS; next bin on same index back to back
      reg_bin(2, 1, "R5");
      reg_bin(2, 1, "R6");
      reg_bin(2, 0, "R5");
      // R7: same index one apart
      reg_bin(4, 1, "R5");
      reg_bin(5, 0, "R7");
      reg_bin(4, 1, "R7");
      // R8: bypass and idle between same index leave the model unchanged
      step(0, '0, '0, 1, 1, 4, 0, "R8");
      reg_bin(4, 0, "R8");
      idle(2);
      reg_bin(4, 1, "R8");
      reg_bin(4, 0, "R9");

      // Random phase, narrow index window
      for (int i = 0; i < 600; i++)
         step(0, '0, '0, ($urandom % 100) < 85, ($urandom % 100) < 20,
              IW'($urandom % 4), 1'($urandom), "R6");
      // Random phase, full index range
      for (int i = 0; i < 600; i++)
         step(0, '0, '0, ($urandom % 100) < 85, ($urandom % 100) < 20,
              IW'($urandom), 1'($urandom), "R7");
      idle(3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule